// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a cycle-accurate model of a synchronous flow-through static RAM with 32-bit words split into four byte lanes. Every control input is captured on the rising clock edge: the word address, three chip selects of mixed polarity, two independent burst-start strobes, a burst-advance input, a global-write input, a byte-write qualifier with four per-lane enables, and a burst-order select. Each edge is classified as deselect, begin burst, continue burst or suspend burst. Each edge is also classified as a read or a write. The low two address bits of a burst come from an internal two-bit counter that steps in linear or interleaved order.

Writes take the data bus sampled at the same edge and update only the enabled byte lanes. Reads are flow-through: once an edge has registered a read address, the word stored there appears on the output during that same cycle. The bidirectional data pins are modelled as a separate read-data bus with a valid flag, which is gated by the asynchronous output enable.

Top module: `burst_sram_model`

## Requirements
- R1: The device counts as selected only when `sel_n_i`=0, `sel2_i`=1 and `sel3_n_i`=0. A begin-burst request made while it is not selected is a deselect cycle. A deselect cycle leaves `rvalid_o` low in the cycle that follows.
- R2: `strb_proc_n_i` is ignored while `sel_n_i`=1. With `strb_ctrl_n_i`=1 in that case, the edge is decoded as a continue or a suspend from `adv_n_i`.
- R3: A burst started by `strb_proc_n_i`=0 with `sel_n_i`=0 is always a read and writes nothing, even when `gwr_n_i`=0.
- R4: A burst started by `strb_ctrl_n_i`=0 while the device is selected, with the processor strobe not in effect, is a read or a write as the write controls decide.
- R5: With both strobes high, `adv_n_i`=0 moves the burst to its next address and `adv_n_i`=1 keeps the current address. The chip selects have no effect on either case.
- R6: Burst order. With `seq_mode_i`=0 (linear), beat n uses low bits (start+n) mod 4. With `seq_mode_i`=1 (interleaved), beat n uses start XOR n. The upper address bits stay fixed. The order is captured when the burst begins, and the order wraps after four beats.
- R7: `gwr_n_i`=0 writes all four byte lanes, whatever `bwr_n_i` and `lane_n_i` are.
- R8: With `gwr_n_i`=1 and `bwr_n_i`=0, lane k (data bits 8k+7:8k) is written only when `lane_n_i[k]`=0. The other lanes keep their contents.
- R9: With `gwr_n_i`=1, the cycle is a read when `bwr_n_i`=1 or when `lane_n_i`=4'b1111.
- R10: `rvalid_o` is 0 and `rdata_o` is 0 when `oe_n_i`=1, in a cycle registered as a write, and when no read is active.
- R11: After an edge that registers a read, `rdata_o` shows the word at the registered burst address within that same cycle. This includes data written by an earlier edge.
- R12: A deselect ends the active burst. After it, continue and suspend cycles neither write nor drive data until a new burst begins.
- R13: After reset, no burst is active and `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address loaded when a burst begins |
| sel_n_i | input | 1 | Primary chip select, active low |
| sel2_i | input | 1 | Second chip select, active high |
| sel3_n_i | input | 1 | Third chip select, active low |
| strb_proc_n_i | input | 1 | Read-only burst-start strobe, active low |
| strb_ctrl_n_i | input | 1 | Read/write burst-start strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwr_n_i | input | 1 | Global write of all lanes, active low |
| bwr_n_i | input | 1 | Byte-write qualifier, active low |
| lane_n_i | input | 4 | Per-lane write enables, active low, bit k for lane k |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | 32 | Write data, sampled at the write edge |
| seq_mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata_o | output | 32 | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data is being driven |

## Verification
Some state can only be reached through a particular history of cycles. One case is a continue or suspend arriving after a deselect has ended a burst. Another is the processor strobe pulled low while the primary select is high, and a third is a burst whose order input changes partway through. The stimulus builds these histories with directed sequences: it opens a burst, steps it, deselects, and then issues writes that must be dropped. A long stretch of weighted random cycles then mixes strobes, selects and write controls so that these histories occur again at random addresses. A bench reference model checks every cycle.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_BEGIN = 2'd1,
        CYC_CONT  = 2'd2,
        CYC_SUSP  = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        XFER_IDLE  = 2'd0,
        XFER_READ  = 2'd1,
        XFER_WRITE = 2'd2
    } xfer_e;
endpackage

// File: rtl/cycle_decoder.sv
module cycle_decoder
    import sbsram_pkg::*;
(
    input  logic             sel_n_i,
    input  logic             sel2_i,
    input  logic             sel3_n_i,
    input  logic             strb_proc_n_i,
    input  logic             strb_ctrl_n_i,
    input  logic             adv_n_i,
    input  logic             gwr_n_i,
    input  logic             bwr_n_i,
    input  logic [LANES-1:0] lane_n_i,
    output cyc_e             cyc_o,
    output logic             wr_o,
    output logic [LANES-1:0] byte_en_o
);
    logic             selected;
    logic             proc_live;
    logic [LANES-1:0] lanes_req;

    always_comb begin
        selected  = !sel_n_i && sel2_i && !sel3_n_i;
        proc_live = !strb_proc_n_i && !sel_n_i;
        if (!gwr_n_i)      lanes_req = '1;
        else if (!bwr_n_i) lanes_req = ~lane_n_i;
        else               lanes_req = '0;

        if (proc_live) begin
            cyc_o = selected ? CYC_BEGIN : CYC_DESEL;
            wr_o  = 1'b0;
        end else if (!strb_ctrl_n_i) begin
            cyc_o = selected ? CYC_BEGIN : CYC_DESEL;
            wr_o  = selected && (|lanes_req);
        end else begin
            cyc_o = adv_n_i ? CYC_SUSP : CYC_CONT;
            wr_o  = |lanes_req;
        end
        byte_en_o = wr_o ? lanes_req : '0;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import sbsram_pkg::*;
(
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              ilv_i,
    output logic [BEAT_W-1:0] low_o
);
    always_comb begin
        if (ilv_i) low_o = start_i ^ beat_i;
        else       low_o = start_i + beat_i;
    end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  byte_en_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && byte_en_i[g]) begin
                mem_q[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem_q[raddr_i];
    end
endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sel_n_i,
    input  logic              sel2_i,
    input  logic              sel3_n_i,
    input  logic              strb_proc_n_i,
    input  logic              strb_ctrl_n_i,
    input  logic              adv_n_i,
    input  logic              gwr_n_i,
    input  logic              bwr_n_i,
    input  logic [3:0]        lane_n_i,
    input  logic              oe_n_i,
    input  logic [31:0]       wdata_i,
    input  logic              seq_mode_i,
    output logic [31:0]       rdata_o,
    output logic              rvalid_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        logic              ilv;
        xfer_e             xfer;
    } burst_t;

    burst_t            st_d, st_q;
    cyc_e              cyc;
    logic              wr;
    logic [LANES-1:0]  byte_en;
    logic [BEAT_W-1:0] low_d, low_q;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              mem_we;
    logic [DATA_W-1:0] arr_rdata;

    cycle_decoder i_dec (
        .sel_n_i       (sel_n_i),
        .sel2_i        (sel2_i),
        .sel3_n_i      (sel3_n_i),
        .strb_proc_n_i (strb_proc_n_i),
        .strb_ctrl_n_i (strb_ctrl_n_i),
        .adv_n_i       (adv_n_i),
        .gwr_n_i       (gwr_n_i),
        .bwr_n_i       (bwr_n_i),
        .lane_n_i      (lane_n_i),
        .cyc_o         (cyc),
        .wr_o          (wr),
        .byte_en_o     (byte_en)
    );

    always_comb begin
        st_d = st_q;
        unique case (cyc)
            CYC_DESEL: begin
                st_d.active = 1'b0;
                st_d.xfer   = XFER_IDLE;
            end
            CYC_BEGIN: begin
                st_d.active = 1'b1;
                st_d.base   = addr_i;
                st_d.beat   = '0;
                st_d.ilv    = seq_mode_i;
                st_d.xfer   = wr ? XFER_WRITE : XFER_READ;
            end
            CYC_CONT: begin
                if (st_q.active) begin
                    st_d.beat = st_q.beat + 1'b1;
                    st_d.xfer = wr ? XFER_WRITE : XFER_READ;
                end else begin
                    st_d.xfer = XFER_IDLE;
                end
            end
            default: begin
                if (st_q.active) st_d.xfer = wr ? XFER_WRITE : XFER_READ;
                else             st_d.xfer = XFER_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    burst_addr_gen i_gen_next (
        .start_i (st_d.base[BEAT_W-1:0]),
        .beat_i  (st_d.beat),
        .ilv_i   (st_d.ilv),
        .low_o   (low_d)
    );

    burst_addr_gen i_gen_cur (
        .start_i (st_q.base[BEAT_W-1:0]),
        .beat_i  (st_q.beat),
        .ilv_i   (st_q.ilv),
        .low_o   (low_q)
    );

    assign waddr  = {st_d.base[ADDR_W-1 -: HI_W], low_d};
    assign raddr  = {st_q.base[ADDR_W-1 -: HI_W], low_q};
    assign mem_we = (st_d.xfer == XFER_WRITE);

    sram_lane_array #(.ADDR_W(ADDR_W)) i_array (
        .clk       (clk),
        .we_i      (mem_we),
        .waddr_i   (waddr),
        .wdata_i   (wdata_i),
        .byte_en_i (byte_en),
        .raddr_i   (raddr),
        .rdata_o   (arr_rdata)
    );

    assign rvalid_o = (st_q.xfer == XFER_READ) && !oe_n_i;
    assign rdata_o  = rvalid_o ? arr_rdata : '0;

    assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |=> !rvalid_o);

    assert_proc_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n_i && !sel_n_i) |-> !mem_we);

    assert_cont_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_CONT && st_q.active) |=> (raddr != $past(raddr)));

    assert_susp_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_SUSP && st_q.active) |=> $stable(raddr));

    assert_write_has_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(byte_en) > 0));

    assert_write_hides_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !rvalid_o);

    assert_idle_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != CYC_BEGIN && !st_q.active) |-> !mem_we);
endmodule

// File: tb/test_burst_sram_model.sv
module test_burst_sram_model;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic          sel_n, sel2, sel3_n, sp_n, sc_n, adv_n, gw_n, bw_n, oe_n, mode;
    logic [3:0]    lane_n;
    logic [31:0]   wd;
    logic [31:0]   rdata;
    logic          rvalid;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // reference state
    logic [31:0]   ref_mem [1 << AW];
    bit            m_active = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    bit            m_ilv = 0;
    int            m_kind = 0; // 0 idle, 1 read, 2 write

    always #2 clk = ~clk;

    burst_sram_model #(.ADDR_W(AW)) i_burst_sram_model (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .sel_n_i(sel_n), .sel2_i(sel2),
        .sel3_n_i(sel3_n), .strb_proc_n_i(sp_n), .strb_ctrl_n_i(sc_n), .adv_n_i(adv_n),
        .gwr_n_i(gw_n), .bwr_n_i(bw_n), .lane_n_i(lane_n), .oe_n_i(oe_n),
        .wdata_i(wd), .seq_mode_i(mode), .rdata_o(rdata), .rvalid_o(rvalid)
    );

    function automatic logic [AW-1:0] cur_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [3:0] lanes_of();
        if (gw_n == 1'b0) return 4'hF;
        if (bw_n == 1'b0) return ~lane_n;
        return 4'h0;
    endfunction

    task automatic ref_edge();
        bit         chosen = (sel_n == 1'b0) && (sel2 == 1'b1) && (sel3_n == 1'b0);
        logic [3:0] ln = lanes_of();
        logic [AW-1:0] a;
        if (sp_n == 1'b0 && sel_n == 1'b0) begin
            if (chosen) begin
                m_active = 1; m_base = addr; m_beat = 0; m_ilv = mode; m_kind = 1;
            end else begin
                m_active = 0; m_kind = 0;
            end
        end else if (sc_n == 1'b0) begin
            if (chosen) begin
                m_active = 1; m_base = addr; m_beat = 0; m_ilv = mode;
                m_kind = (ln != 0) ? 2 : 1;
            end else begin
                m_active = 0; m_kind = 0;
            end
        end else if (m_active) begin
            if (adv_n == 1'b0) m_beat = m_beat + 2'd1;
            m_kind = (ln != 0) ? 2 : 1;
        end else begin
            m_kind = 0;
        end
        if (m_kind == 2) begin
            a = cur_addr();
            for (int k = 0; k < 4; k++)
                if (ln[k]) ref_mem[a][8*k +: 8] = wd[8*k +: 8];
        end
    endtask

    task automatic compare(input string tag);
        logic        ev = (m_kind == 1) && (oe_n == 1'b0);
        logic [31:0] ed = ev ? ref_mem[cur_addr()] : 32'h0;
        vectors++;
        if (rvalid !== ev || rdata !== ed) begin
            misses++;
            $display("FAIL %s rvalid=%0b exp %0b rdata=%h exp %h", tag, rvalid, ev, rdata, ed);
        end
    endtask

    task automatic tick(input string tag);
        ref_edge();
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic quiet();
        sel_n = 0; sel2 = 1; sel3_n = 0; sp_n = 1; sc_n = 1; adv_n = 1;
        gw_n = 1; bw_n = 1; lane_n = 4'hF; oe_n = 0; mode = 0; addr = '0; wd = '0;
    endtask

    task automatic ctrl_begin(input logic [AW-1:0] a, input logic m);
        quiet(); sc_n = 0; addr = a; mode = m;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(20240611);
        quiet();
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        compare("R13 reset");

        // fill every word with a global write
        for (int i = 0; i < (1 << AW); i++) begin
            ctrl_begin(i[AW-1:0], 0); gw_n = 0; wd = (i * 32'h01010101) ^ 32'hA5000000;
            tick("R7 fill");
        end
        ctrl_begin(8'h05, 0); tick("R7 readback");

        // processor-strobe burst never writes
        quiet(); sp_n = 0; addr = 8'h10; gw_n = 0; wd = 32'hDEADBEEF; tick("R3");
        ctrl_begin(8'h10, 0); tick("R3 unchanged");

        // linear burst from 0x21 with wrap
        ctrl_begin(8'h21, 0); tick("R4 begin read");
        for (int n = 0; n < 4; n++) begin quiet(); adv_n = 0; tick("R6 linear"); end

        // interleaved burst from 0x22, mode input flipped mid-burst
        ctrl_begin(8'h22, 1); tick("R6 start");
        for (int n = 0; n < 3; n++) begin quiet(); adv_n = 0; mode = 0; tick("R6 interleaved"); end

        // suspend and continue with the chip not selected
        quiet(); sel_n = 1; sel2 = 0; tick("R5 suspend");
        quiet(); sel_n = 1; adv_n = 0; tick("R5 continue");

        // processor strobe ignored while primary select high
        quiet(); sel_n = 1; sp_n = 0; adv_n = 0; tick("R2");

        // per-lane write then readback
        ctrl_begin(8'h40, 0); bw_n = 0; lane_n = 4'b1010; wd = 32'hFFFFFFFF; tick("R8 write");
        ctrl_begin(8'h40, 0); tick("R8 readback");
        ctrl_begin(8'h41, 0); bw_n = 1; lane_n = 4'h0; wd = 32'h12345678; tick("R9 bwr high");
        ctrl_begin(8'h42, 0); bw_n = 0; lane_n = 4'hF; wd = 32'h12345678; tick("R9 no lane");

        // output enable gating
        ctrl_begin(8'h43, 0); oe_n = 1; tick("R10 oe high");
        quiet(); oe_n = 0; tick("R10 oe low");

        // write then immediate read of the same word
        ctrl_begin(8'h50, 0); gw_n = 0; wd = 32'hCAFEF00D; tick("R10 write cycle");
        ctrl_begin(8'h50, 0); tick("R11 flow-through");

        // deselect ends the burst
        ctrl_begin(8'h60, 0); sel2 = 0; tick("R1 ctrl deselect");
        quiet(); adv_n = 0; gw_n = 0; wd = 32'h0BADBAD0; tick("R12 continue dropped");
        quiet(); gw_n = 0; wd = 32'h0BADBAD0; tick("R12 suspend dropped");
        ctrl_begin(8'h60, 0); tick("R12 memory intact");
        quiet(); sp_n = 0; sel3_n = 1; addr = 8'h61; tick("R1 proc deselect");
        quiet(); adv_n = 0; tick("R12 idle");

        // weighted random traffic
        for (int n = 0; n < 4000; n++) begin
            sp_n   = ($urandom_range(0, 99) >= 12);
            sc_n   = ($urandom_range(0, 99) >= 20);
            adv_n  = $urandom_range(0, 1);
            sel_n  = ($urandom_range(0, 99) < 8);
            sel2   = ($urandom_range(0, 99) >= 8);
            sel3_n = ($urandom_range(0, 99) < 8);
            gw_n   = ($urandom_range(0, 99) >= 15);
            bw_n   = ($urandom_range(0, 99) >= 40);
            lane_n = 4'($urandom_range(0, 15));
            oe_n   = ($urandom_range(0, 99) < 12);
            mode   = $urandom_range(0, 1);
            addr   = AW'($urandom_range(0, (1 << AW) - 1));
            wd     = $urandom;
            tick("R11 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired rvalid=%0b exp 0 rdata=%h exp 0", rvalid, rdata);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule